// File: doc/BRIEF.md
# ECC-Protected Interrupt Vector Table

This block stores one 32-bit handler address for each interrupt channel in a small RAM. Seven check bits sit beside every word. A CPU port writes and reads whole words. A lookup port lets the interrupt controller fetch the vector of the request that won arbitration; the result appears on an IRQ vector output or on an FIQ vector output. Both ports return data one clock after the request.

Check bits are generated on a write only while ECC is armed. ECC is armed only when a 4-bit key input holds 4'b1010, and it is off after reset. On every read the check bits are computed again and compared with the stored ones, using a Hamming code plus one overall parity bit.

- A single-bit error is logged. It is corrected only when correction is switched on.
- A double-bit error is logged and the raw word is returned. From then on a software-supplied fall-back address replaces both vector outputs until software clears the uncorrectable-error flag.

Error flags are write-one-to-clear pulse inputs. Each flag keeps the address of the first word that failed.

Top module: `vec_table_ecc`

## Requirements
- R1: A granted CPU write stores `cpu_wdata` at `cpu_addr`. A granted CPU read drives the stored word on `cpu_rdata` in the clock cycle after the request edge.
- R2: A lookup drives the addressed word in the cycle after the request edge. It appears on `irq_vec` when `lk_fiq`=0 and on `fiq_vec` when `lk_fiq`=1. Each output keeps its last lookup value until the next lookup of its own kind, and both outputs reset to 0.
- R3: When `lk_en` and `cpu_en` are high in the same cycle, the lookup is served and `cpu_gnt` is 0. The CPU access is dropped, so a write in that cycle leaves the table unchanged.
- R4: ECC is armed only while `ecc_key` equals 4'b1010. While it is not armed: no error flag, address or error output changes, reads return raw data, and writes leave the stored check bits unchanged.
- R5: While ECC is armed, a read whose word has one flipped bit sets `sbe_flag` and captures the word index in `sbe_addr` at the edge after the data cycle. The returned data is corrected when `corr_en`=1 and raw when `corr_en`=0.
- R6: `err_sbe_o` pulses in the data cycle of a single-bit error only when `sbe_irq_en`=1.
- R7: While ECC is armed, a read with two flipped bits returns the raw word and pulses `err_ube_o` in the data cycle. It also sets `ube_flag` and captures `ube_addr` at the next edge.
- R8: While `ube_flag` is 1, and during the data cycle of a lookup that hits a double-bit error, both `irq_vec` and `fiq_vec` show `fb_vec`. After the flag is cleared, the held lookup values return.
- R9: A one-cycle pulse on `clr_sbe` or `clr_ube` clears the matching flag at that edge; a new error in the same cycle wins over the clear. While a flag is set, its address register keeps the first failing address.
- R10: After reset both flags, both addresses, both vector outputs and both error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ecc_key | input | 4 | ECC arm key, 4'b1010 arms |
| corr_en | input | 1 | Apply single-bit correction to read data |
| sbe_irq_en | input | 1 | Allow single-bit errors to drive `err_sbe_o` |
| fb_vec | input | 32 | Fall-back vector used while an uncorrectable error is pending |
| clr_sbe | input | 1 | Clear pulse for the single-bit error flag |
| clr_ube | input | 1 | Clear pulse for the uncorrectable error flag |
| cpu_en | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | AW | CPU word index |
| cpu_wdata | input | 32 | CPU write data |
| cpu_gnt | output | 1 | CPU access accepted this cycle |
| cpu_rdata | output | 32 | CPU read data, valid the cycle after a granted read |
| lk_en | input | 1 | Lookup request |
| lk_fiq | input | 1 | Lookup targets the FIQ output |
| lk_addr | input | AW | Lookup word index |
| irq_vec | output | 32 | IRQ vector |
| fiq_vec | output | 32 | FIQ vector |
| sbe_flag | output | 1 | Single-bit error logged |
| ube_flag | output | 1 | Uncorrectable error logged |
| sbe_addr | output | AW | First single-bit error address |
| ube_addr | output | AW | First uncorrectable error address |
| err_sbe_o | output | 1 | Single-bit error event toward the error collector |
| err_ube_o | output | 1 | Double-bit error event toward the error collector |

## Verification
The bench builds the table with DEPTH=16. This makes the top index 15 and the low index 0 part of the vector walk, and keeps the address registers 4 bits wide so captured indices are easy to compare. Errors are injected through the normal ports: a word is written with ECC armed, the key is dropped, and the data is rewritten with one or two bits flipped. This exercises the rule that check bits are not updated while disarmed, along with correction, logging, first-address holding and the fall-back vector.

// File: rtl/vte_pkg.sv
package vte_pkg;
  localparam int VTE_DW = 32;
  localparam int VTE_CW = 7;
  localparam int VTE_SW = 6;
  localparam logic [3:0] VTE_KEY_ARM = 4'b1010;

  // Hamming position of data bit d: the d-th non-power-of-two in 3..38
  function automatic logic [VTE_SW-1:0] vte_dpos(input int d);
    logic [VTE_SW-1:0] r;
    int seen;
    r = '0;
    seen = 0;
    for (int q = 3; q <= 38; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (seen == d) r = VTE_SW'(q);
        seen++;
      end
    end
    return r;
  endfunction

  function automatic logic [VTE_CW-1:0] vte_chk_gen(input logic [VTE_DW-1:0] d);
    logic [VTE_CW-1:0] c;
    logic [VTE_SW-1:0] p;
    c = '0;
    for (int i = 0; i < VTE_DW; i++) begin
      p = vte_dpos(i);
      for (int b = 0; b < VTE_SW; b++)
        if (p[b]) c[b] = c[b] ^ d[i];
    end
    c[VTE_CW-1] = ^d ^ ^c[VTE_SW-1:0];
    return c;
  endfunction
endpackage

// File: rtl/vte_ecc_enc.sv
module vte_ecc_enc
  import vte_pkg::*;
(
  input  logic [VTE_DW-1:0] data,
  output logic [VTE_CW-1:0] chk
);
  always_comb chk = vte_chk_gen(data);
endmodule

// File: rtl/vte_ecc_dec.sv
module vte_ecc_dec
  import vte_pkg::*;
(
  input  logic [VTE_DW-1:0] raw_data,
  input  logic [VTE_CW-1:0] raw_chk,
  input  logic              fix_en,
  output logic [VTE_DW-1:0] data_out,
  output logic              sbe,
  output logic              dbe
);
  logic [VTE_CW-1:0] calc;
  logic [VTE_SW-1:0] syn;
  logic              par;
  logic [VTE_DW-1:0] fixed;

  always_comb begin
    calc  = vte_chk_gen(raw_data);
    syn   = calc[VTE_SW-1:0] ^ raw_chk[VTE_SW-1:0];
    par   = ^raw_data ^ ^raw_chk;
    sbe   = par;
    dbe   = ~par & (|syn);
    fixed = raw_data;
    for (int i = 0; i < VTE_DW; i++)
      if (sbe && (vte_dpos(i) == syn)) fixed[i] = ~raw_data[i];
    data_out = fix_en ? fixed : raw_data;
  end
endmodule

// File: rtl/vte_err_log.sv
module vte_err_log #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic          sbe_ev,
  input  logic          dbe_ev,
  input  logic [AW-1:0] ev_addr,
  input  logic          clr_sbe,
  input  logic          clr_ube,
  output logic          sbe_flag,
  output logic          ube_flag,
  output logic [AW-1:0] sbe_addr,
  output logic [AW-1:0] ube_addr
);
  logic          sbe_set, ube_set;
  logic          sbe_flag_d, ube_flag_d;
  logic [AW-1:0] sbe_addr_d, ube_addr_d;

  always_comb begin
    sbe_set    = ev_valid & sbe_ev;
    ube_set    = ev_valid & dbe_ev;
    sbe_flag_d = sbe_flag;
    ube_flag_d = ube_flag;
    sbe_addr_d = sbe_addr;
    ube_addr_d = ube_addr;
    if (clr_sbe) sbe_flag_d = 1'b0;
    if (clr_ube) ube_flag_d = 1'b0;
    if (sbe_set) begin
      sbe_flag_d = 1'b1;
      if (!sbe_flag || clr_sbe) sbe_addr_d = ev_addr;
    end
    if (ube_set) begin
      ube_flag_d = 1'b1;
      if (!ube_flag || clr_ube) ube_addr_d = ev_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbe_flag <= 1'b0;
      ube_flag <= 1'b0;
      sbe_addr <= '0;
      ube_addr <= '0;
    end else begin
      sbe_flag <= sbe_flag_d;
      ube_flag <= ube_flag_d;
      sbe_addr <= sbe_addr_d;
      ube_addr <= ube_addr_d;
    end
  end

  p_sbe_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_flag && !clr_sbe) |=> (sbe_flag && $stable(sbe_addr)));
  p_ube_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ube_flag && !clr_ube) |=> (ube_flag && $stable(ube_addr)));
  p_sbe_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sbe && !(ev_valid && sbe_ev)) |=> !sbe_flag);
  p_ube_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ube && !(ev_valid && dbe_ev)) |=> !ube_flag);
endmodule

// File: rtl/vec_table_ecc.sv
module vec_table_ecc
  import vte_pkg::*;
#(
  parameter  int DEPTH = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        ecc_key,
  input  logic              corr_en,
  input  logic              sbe_irq_en,
  input  logic [VTE_DW-1:0] fb_vec,
  input  logic              clr_sbe,
  input  logic              clr_ube,
  input  logic              cpu_en,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [VTE_DW-1:0] cpu_wdata,
  output logic              cpu_gnt,
  output logic [VTE_DW-1:0] cpu_rdata,
  input  logic              lk_en,
  input  logic              lk_fiq,
  input  logic [AW-1:0]     lk_addr,
  output logic [VTE_DW-1:0] irq_vec,
  output logic [VTE_DW-1:0] fiq_vec,
  output logic              sbe_flag,
  output logic              ube_flag,
  output logic [AW-1:0]     sbe_addr,
  output logic [AW-1:0]     ube_addr,
  output logic              err_sbe_o,
  output logic              err_ube_o
);
  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic [VTE_DW-1:0] dmem [DEPTH];
  logic [VTE_CW-1:0] cmem [DEPTH];

  logic              ecc_on, mem_rd, mem_wr;
  logic [AW-1:0]     mem_addr;
  logic [VTE_CW-1:0] wchk;
  logic [VTE_DW-1:0] rd_d_q;
  logic [VTE_CW-1:0] rd_c_q;

  // access arbitration: lookup wins
  always_comb begin
    ecc_on   = (ecc_key == VTE_KEY_ARM);
    cpu_gnt  = cpu_en & ~lk_en;
    mem_wr   = cpu_gnt & cpu_we;
    mem_rd   = lk_en | (cpu_gnt & ~cpu_we);
    mem_addr = lk_en ? lk_addr : cpu_addr;
  end

  vte_ecc_enc u_enc (.data(cpu_wdata), .chk(wchk));

  always_ff @(posedge clk) begin
    if (mem_wr) begin
      dmem[cpu_addr] <= cpu_wdata;
      if (ecc_on) cmem[cpu_addr] <= wchk;
    end
    if (mem_rd) begin
      rd_d_q <= dmem[mem_addr];
      rd_c_q <= cmem[mem_addr];
    end
  end

  // read pipeline control
  logic          rd_v_q, rd_lk_q, rd_fiq_q;
  logic [AW-1:0] rd_addr_q;
  logic          rd_v_d, rd_lk_d, rd_fiq_d;
  logic [AW-1:0] rd_addr_d;

  always_comb begin
    rd_v_d    = mem_rd;
    rd_lk_d   = lk_en;
    rd_fiq_d  = lk_fiq & lk_en;
    rd_addr_d = mem_addr;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rd_v_q    <= 1'b0;
      rd_lk_q   <= 1'b0;
      rd_fiq_q  <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_v_q    <= rd_v_d;
      rd_lk_q   <= rd_lk_d;
      rd_fiq_q  <= rd_fiq_d;
      rd_addr_q <= rd_addr_d;
    end
  end

  logic [VTE_DW-1:0] dec_data;
  logic              sbe_raw, dbe_raw, sbe_ev, dbe_ev;

  vte_ecc_dec u_dec (
    .raw_data (rd_d_q),
    .raw_chk  (rd_c_q),
    .fix_en   (corr_en & ecc_on),
    .data_out (dec_data),
    .sbe      (sbe_raw),
    .dbe      (dbe_raw)
  );

  always_comb begin
    sbe_ev    = rd_v_q & ecc_on & sbe_raw;
    dbe_ev    = rd_v_q & ecc_on & dbe_raw;
    err_sbe_o = sbe_ev & sbe_irq_en;
    err_ube_o = dbe_ev;
    cpu_rdata = dec_data;
  end

  vte_err_log #(.AW(AW)) u_log (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ev_valid (rd_v_q & ecc_on),
    .sbe_ev   (sbe_raw),
    .dbe_ev   (dbe_raw),
    .ev_addr  (rd_addr_q),
    .clr_sbe  (clr_sbe),
    .clr_ube  (clr_ube),
    .sbe_flag (sbe_flag),
    .ube_flag (ube_flag),
    .sbe_addr (sbe_addr),
    .ube_addr (ube_addr)
  );

  // vector outputs: live lookup result, else held value, fall-back overrides
  logic              lk_irq_v, lk_fiq_v, use_fb;
  logic [VTE_DW-1:0] irq_hold_q, fiq_hold_q, irq_hold_d, fiq_hold_d;

  always_comb begin
    lk_irq_v   = rd_v_q & rd_lk_q & ~rd_fiq_q;
    lk_fiq_v   = rd_v_q & rd_lk_q & rd_fiq_q;
    use_fb     = ube_flag | ((lk_irq_v | lk_fiq_v) & dbe_ev);
    irq_hold_d = lk_irq_v ? dec_data : irq_hold_q;
    fiq_hold_d = lk_fiq_v ? dec_data : fiq_hold_q;
    irq_vec    = use_fb ? fb_vec : irq_hold_d;
    fiq_vec    = use_fb ? fb_vec : fiq_hold_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      irq_hold_q <= '0;
      fiq_hold_q <= '0;
    end else begin
      if (lk_irq_v) irq_hold_q <= irq_hold_d;
      if (lk_fiq_v) fiq_hold_q <= fiq_hold_d;
    end
  end

  p_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    ube_flag |-> (irq_vec == fb_vec && fiq_vec == fb_vec));
  p_ube_logged_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_ube_o |=> ube_flag);
  p_sbe_logged_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_sbe_o |=> sbe_flag);
  p_disarmed_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ecc_key != VTE_KEY_ARM) |-> (!err_sbe_o && !err_ube_o));
endmodule

// File: tb/vec_table_ecc_tb_top.sv
module vec_table_ecc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam logic [31:0] FB = 32'hDEAD_0000;
  localparam int NVEC = 6;
  // {fiq, addr, data}
  localparam logic [AW+32:0] VECS [NVEC] = '{
    {1'b0, 4'd0,  32'h0000_1000},
    {1'b1, 4'd15, 32'hFFFF_FFFC},
    {1'b0, 4'd7,  32'hA5A5_5A5A},
    {1'b1, 4'd3,  32'h0000_0000},
    {1'b0, 4'd9,  32'h8000_0001},
    {1'b1, 4'd12, 32'h1234_5678}
  };

  logic clk = 0, rst_n = 0;
  logic [3:0] ecc_key = 4'b1010;
  logic corr_en = 1, sbe_irq_en = 1, clr_sbe = 0, clr_ube = 0;
  logic [31:0] fb_vec = FB;
  logic cpu_en = 0, cpu_we = 0, lk_en = 0, lk_fiq = 0;
  logic [AW-1:0] cpu_addr = '0, lk_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic cpu_gnt, sbe_flag, ube_flag, err_sbe_o, err_ube_o;
  logic [31:0] cpu_rdata, irq_vec, fiq_vec;
  logic [AW-1:0] sbe_addr, ube_addr;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_table_ecc #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ecc_key(ecc_key), .corr_en(corr_en),
    .sbe_irq_en(sbe_irq_en), .fb_vec(fb_vec), .clr_sbe(clr_sbe), .clr_ube(clr_ube),
    .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_gnt(cpu_gnt), .cpu_rdata(cpu_rdata), .lk_en(lk_en), .lk_fiq(lk_fiq),
    .lk_addr(lk_addr), .irq_vec(irq_vec), .fiq_vec(fiq_vec), .sbe_flag(sbe_flag),
    .ube_flag(ube_flag), .sbe_addr(sbe_addr), .ube_addr(ube_addr),
    .err_sbe_o(err_sbe_o), .err_ube_o(err_ube_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cpu_wr(input logic [AW-1:0] a, input logic [31:0] d);
    cpu_en = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_en = 0; cpu_we = 0;
  endtask

  // samples data in the cycle after the request edge
  task automatic cpu_rd(input logic [AW-1:0] a, output logic [31:0] d,
                        output logic es, output logic eu);
    cpu_en = 1; cpu_we = 0; cpu_addr = a;
    @(negedge clk);
    cpu_en = 0;
    d = cpu_rdata; es = err_sbe_o; eu = err_ube_o;
  endtask

  task automatic lookup(input logic [AW-1:0] a, input logic f,
                        output logic [31:0] iv, output logic [31:0] fv, output logic eu);
    lk_en = 1; lk_fiq = f; lk_addr = a;
    @(negedge clk);
    lk_en = 0; lk_fiq = 0;
    iv = irq_vec; fv = fiq_vec; eu = err_ube_o;
  endtask

  // store good with check bits, then overwrite data while disarmed
  task automatic inject(input logic [AW-1:0] a, input logic [31:0] good, input logic [31:0] bad);
    ecc_key = 4'b1010;
    cpu_wr(a, good);
    ecc_key = 4'b0000;
    cpu_wr(a, bad);
    ecc_key = 4'b1010;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, iv, fv;
    logic es, eu;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 sbe_flag", {31'd0, sbe_flag}, 0);
    chk("R10 ube_flag", {31'd0, ube_flag}, 0);
    chk("R10 sbe_addr", {28'd0, sbe_addr}, 0);
    chk("R10 ube_addr", {28'd0, ube_addr}, 0);
    chk("R10 irq_vec", irq_vec, 0);
    chk("R10 fiq_vec", fiq_vec, 0);
    chk("R10 err outs", {30'd0, err_sbe_o, err_ube_o}, 0);

    // vector walk: R1 CPU path, R2 lookup path
    for (int i = 0; i < NVEC; i++) begin
      cpu_wr(VECS[i][AW+31:32], VECS[i][31:0]);
      cpu_rd(VECS[i][AW+31:32], d, es, eu);
      chk("R1 cpu readback", d, VECS[i][31:0]);
      lookup(VECS[i][AW+31:32], VECS[i][AW+32], iv, fv, eu);
      chk("R2 lookup vec", VECS[i][AW+32] ? fv : iv, VECS[i][31:0]);
    end
    @(negedge clk);
    chk("R2 irq held", irq_vec, 32'h8000_0001);
    chk("R2 fiq held", fiq_vec, 32'h1234_5678);
    chk("R10 no flag after clean reads", {30'd0, sbe_flag, ube_flag}, 0);

    // R3 same-cycle conflict
    lk_en = 1; lk_fiq = 0; lk_addr = 0;
    cpu_en = 1; cpu_we = 1; cpu_addr = 0; cpu_wdata = 32'h5555_5555;
    #1;
    chk("R3 cpu_gnt low", {31'd0, cpu_gnt}, 0);
    @(negedge clk);
    lk_en = 0; cpu_en = 0; cpu_we = 0;
    chk("R3 lookup served", irq_vec, 32'h0000_1000);
    cpu_rd(0, d, es, eu);
    chk("R3 write dropped", d, 32'h0000_1000);

    // R4 disarmed key: corrupted word read raw, no events
    inject(5, 32'h0F0F_0000, 32'h0F0F_0008);
    ecc_key = 4'b0101;
    cpu_rd(5, d, es, eu);
    chk("R4 raw data", d, 32'h0F0F_0008);
    chk("R4 no err_sbe_o", {31'd0, es}, 0);
    @(negedge clk);
    chk("R4 no sbe_flag", {31'd0, sbe_flag}, 0);
    ecc_key = 4'b1010;

    // R5/R6 corrected single error with interrupt enable
    cpu_rd(5, d, es, eu);
    chk("R5 corrected", d, 32'h0F0F_0000);
    chk("R6 err_sbe_o with enable", {31'd0, es}, 1);
    @(negedge clk);
    chk("R5 sbe_flag", {31'd0, sbe_flag}, 1);
    chk("R5 sbe_addr", {28'd0, sbe_addr}, 5);

    // R9 second single error: address held; R5 raw; R6 masked
    inject(6, 32'h7000_0001, 32'hF000_0001);
    corr_en = 0; sbe_irq_en = 0;
    cpu_rd(6, d, es, eu);
    chk("R5 raw when correction off", d, 32'hF000_0001);
    chk("R6 err_sbe_o masked", {31'd0, es}, 0);
    @(negedge clk);
    chk("R9 first address held", {28'd0, sbe_addr}, 5);
    clr_sbe = 1;
    @(negedge clk);
    clr_sbe = 0;
    chk("R9 sbe cleared", {31'd0, sbe_flag}, 0);
    cpu_rd(6, d, es, eu);
    @(negedge clk);
    chk("R9 new address after clear", {28'd0, sbe_addr}, 6);
    corr_en = 1;

    // R7/R8 double error on a lookup
    inject(8, 32'h0000_00F0, 32'h0000_00F3);
    lookup(8, 0, iv, fv, eu);
    chk("R8 fallback on failing lookup", iv, FB);
    chk("R7 err_ube_o", {31'd0, eu}, 1);
    @(negedge clk);
    chk("R7 ube_flag", {31'd0, ube_flag}, 1);
    chk("R7 ube_addr", {28'd0, ube_addr}, 8);
    chk("R8 fiq fallback", fiq_vec, FB);
    cpu_rd(8, d, es, eu);
    chk("R7 raw data on double error", d, 32'h0000_00F3);
    lookup(0, 0, iv, fv, eu);
    chk("R8 fallback while flagged", iv, FB);
    clr_ube = 1;
    @(negedge clk);
    clr_ube = 0;
    chk("R9 ube cleared", {31'd0, ube_flag}, 0);
    chk("R8 irq resumes", irq_vec, 32'h0000_1000);
    chk("R8 fiq resumes", fiq_vec, 32'h1234_5678);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule